// File: doc/BRIEF.md
# CAN Error Confinement and Status Tracker

This block holds the fault-confinement state of a CAN node. The bit-stream engine gives it one-cycle event pulses: a frame sent cleanly, a frame received cleanly, or a protocol error together with its 3-bit type code and a flag telling whether the node was the transmitter at the time. From these the block keeps a transmit error count and a receive error count. It derives three level flags from the counts: warning, passive and bus-off. It also records the type of the most recent bus event and raises a pending interrupt whenever one of the three flags changes.

A host reads two words: the 8-bit status word and the 16-bit counter word. It may write the status word. A write loads the event-code field from the written data, clears both success flags and acknowledges the pending interrupt. By writing the sentinel code 7, the host can later tell whether any bus event has occurred since that write. Bus-off is sticky. Only the recovery input, which the surrounding controller drives, clears the counters and releases bus-off.

Top module: `can_err_tracker`

## Requirements
- R1: After synchronous reset the status word, the counter word and the interrupt word all read 0 and `irq_o` is low.
- R2: Status bits [2:0] hold the last event code. An error event loads its type (1 stuff, 2 form, 3 acknowledge, 4 bit-1, 5 bit-0, 6 CRC). A clean frame with no error in the same cycle loads 0.
- R3: A host status write loads bits [2:0] from the written data. The value, including the sentinel 7, holds until the next bus event. A bus event in the same cycle as the write takes precedence.
- R4: Status bit 4 sets on a clean receive and bit 3 sets on a clean transmit. A host status write clears both, unless the matching event arrives in the same cycle.
- R5: A transmit-side error adds 8 to the transmit count. A receive-side error adds 1 to the receive count, which saturates at 128. Each clean frame lowers its own count by 1 and never goes below 0.
- R6: Counter word bits [7:0] show the transmit count, or 255 once the count is above 255. Bits [14:8] show the low 7 bits of the receive count. Bit 15 is set while the receive count is above 127.
- R7: Status bit 6 (warning) is set while either count is 96 or more.
- R8: Status bit 5 (passive) is set while either count is above 127.
- R9: Status bit 7 (bus-off) sets in the same cycle that the transmit count goes above 255. It stays set, and both counts stay frozen, until recovery.
- R10: Asserting `recover_i` clears both counts and bus-off on the next clock edge.
- R11: Any change of status bits [7:5] sets the pending interrupt in the same cycle. The pending interrupt drives `irq_o` high and makes the interrupt word read 0x8000. A host status write clears it, unless a flag changes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_ok_i | input | 1 | Pulse: frame transmitted cleanly |
| ev_rx_ok_i | input | 1 | Pulse: frame received cleanly |
| ev_err_i | input | 1 | Pulse: protocol error detected |
| ev_err_code_i | input | 3 | Error type code, valid with ev_err_i |
| ev_err_tx_i | input | 1 | Error occurred while this node transmitted |
| recover_i | input | 1 | Clear counters and leave bus-off |
| host_wr_i | input | 1 | Host write strobe for the status word |
| host_wdata_i | input | 8 | Host write data for the status word |
| status_o | output | 8 | Status word |
| errcnt_o | output | 16 | Counter word |
| int_reg_o | output | 16 | Interrupt word, 0x8000 while pending |
| irq_o | output | 1 | Pending status interrupt |

## Verification
Every state element reaches the ports one clock edge after the event that moves it, so a wrong counter value shows in the counter word at the next sample. The error flags are driven by the two counts, so an off-by-one increment or threshold shows as a flag changing one event too early or too late. That is why the bench walks each count across 95/96, 127/128 and 255/256. A lost or spurious interrupt shows on `irq_o` in the same cycle as the flag change. A bus-off state that fails to stick, or a counter that keeps moving during bus-off, shows in the first ignored event after the crossing.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

  typedef enum logic [2:0] {
    EVC_CLEAN = 3'd0,
    EVC_STUFF = 3'd1,
    EVC_FORM  = 3'd2,
    EVC_ACK   = 3'd3,
    EVC_BIT1  = 3'd4,
    EVC_BIT0  = 3'd5,
    EVC_CRC   = 3'd6,
    EVC_IDLE  = 3'd7
  } evcode_e;

  localparam int SB_OFF  = 7;
  localparam int SB_WARN = 6;
  localparam int SB_PASS = 5;
  localparam int SB_RXOK = 4;
  localparam int SB_TXOK = 3;

  localparam int EVC_W = 3;

  typedef struct packed {
    logic off;
    logic warn;
    logic pass;
  } conf_t;

endpackage

// File: rtl/can_err_counter.sv
module can_err_counter #(
  parameter int W    = 9,
  parameter int STEP = 8,
  parameter int CAP  = 263
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         freeze,
  input  logic         bump,
  input  logic         drop,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  localparam logic [W:0] STEP_V = (W+1)'(STEP);
  localparam logic [W:0] CAP_V  = (W+1)'(CAP);

  logic [W:0] sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + STEP_V;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (!freeze) begin
      if (bump) begin
        cnt_d = (sum > CAP_V) ? CAP_V[W-1:0] : sum[W-1:0];
      end else if (drop && cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_err_confine.sv
module can_err_confine
  import can_err_pkg::*;
#(
  parameter int TW       = 9,
  parameter int RW       = 8,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 127,
  parameter int OFF_LVL  = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tec_d,
  input  logic [RW-1:0] rec_d,
  input  logic          recover,
  input  logic          ack,
  output conf_t         conf_q,
  output logic          pend_q
);
  conf_t conf_d;
  logic  changed;

  always_comb begin
    conf_d.warn = (int'(tec_d) >= WARN_LVL) || (int'(rec_d) >= WARN_LVL);
    conf_d.pass = (int'(tec_d) >  PASS_LVL) || (int'(rec_d) >  PASS_LVL);
    conf_d.off  = recover ? 1'b0 : (conf_q.off || (int'(tec_d) > OFF_LVL));
    changed     = (conf_d != conf_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conf_q <= '0;
      pend_q <= 1'b0;
    end else begin
      conf_q <= conf_d;
      if (changed)  pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             err,
  input  logic [EVC_W-1:0] err_code,
  input  logic             host_wr,
  input  logic [EVC_W-1:0] host_code,
  output logic [EVC_W-1:0] code_q,
  output logic             txok_q,
  output logic             rxok_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= EVC_CLEAN;
      txok_q <= 1'b0;
      rxok_q <= 1'b0;
    end else begin
      if (err)                 code_q <= err_code;
      else if (tx_ok || rx_ok) code_q <= EVC_CLEAN;
      else if (host_wr)        code_q <= host_code;

      if (tx_ok)        txok_q <= 1'b1;
      else if (host_wr) txok_q <= 1'b0;

      if (rx_ok)        rxok_q <= 1'b1;
      else if (host_wr) rxok_q <= 1'b0;
    end
  end
endmodule

// File: rtl/can_err_tracker.sv
module can_err_tracker
  import can_err_pkg::*;
#(
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 127,
  parameter int OFF_LVL  = 255,
  parameter int TX_STEP  = 8,
  parameter int RX_STEP  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_tx_ok_i,
  input  logic        ev_rx_ok_i,
  input  logic        ev_err_i,
  input  logic [2:0]  ev_err_code_i,
  input  logic        ev_err_tx_i,
  input  logic        recover_i,
  input  logic        host_wr_i,
  input  logic [7:0]  host_wdata_i,
  output logic [7:0]  status_o,
  output logic [15:0] errcnt_o,
  output logic [15:0] int_reg_o,
  output logic        irq_o
);
  localparam int TEC_CAP = OFF_LVL + TX_STEP;
  localparam int REC_CAP = PASS_LVL + 1;
  localparam int TW      = $clog2(TEC_CAP + 1);
  localparam int RW      = $clog2(REC_CAP + 1);

  logic [TW-1:0]    tec_q, tec_d;
  logic [RW-1:0]    rec_q, rec_d;
  conf_t            conf;
  logic             pend;
  logic [EVC_W-1:0] code;
  logic             txok, rxok;

  can_err_counter #(.W(TW), .STEP(TX_STEP), .CAP(TEC_CAP)) u_tec (
    .clk(clk), .rst(rst), .clr(recover_i), .freeze(conf.off),
    .bump(ev_err_i && ev_err_tx_i), .drop(ev_tx_ok_i),
    .cnt_q(tec_q), .cnt_d(tec_d)
  );

  can_err_counter #(.W(RW), .STEP(RX_STEP), .CAP(REC_CAP)) u_rec (
    .clk(clk), .rst(rst), .clr(recover_i), .freeze(conf.off),
    .bump(ev_err_i && !ev_err_tx_i), .drop(ev_rx_ok_i),
    .cnt_q(rec_q), .cnt_d(rec_d)
  );

  can_err_confine #(
    .TW(TW), .RW(RW), .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL), .OFF_LVL(OFF_LVL)
  ) u_conf (
    .clk(clk), .rst(rst), .tec_d(tec_d), .rec_d(rec_d),
    .recover(recover_i), .ack(host_wr_i), .conf_q(conf), .pend_q(pend)
  );

  can_err_status u_stat (
    .clk(clk), .rst(rst), .tx_ok(ev_tx_ok_i), .rx_ok(ev_rx_ok_i),
    .err(ev_err_i), .err_code(ev_err_code_i), .host_wr(host_wr_i),
    .host_code(host_wdata_i[EVC_W-1:0]), .code_q(code), .txok_q(txok), .rxok_q(rxok)
  );

  always_comb begin
    status_o            = '0;
    status_o[SB_OFF]    = conf.off;
    status_o[SB_WARN]   = conf.warn;
    status_o[SB_PASS]   = conf.pass;
    status_o[SB_RXOK]   = rxok;
    status_o[SB_TXOK]   = txok;
    status_o[EVC_W-1:0] = code;

    errcnt_o[7:0]   = (int'(tec_q) > 255) ? 8'hFF : tec_q[7:0];
    errcnt_o[14:8]  = rec_q[6:0];
    errcnt_o[15]    = (int'(rec_q) > PASS_LVL);

    int_reg_o = {pend, 15'b0};
    irq_o     = pend;
  end
endmodule

// File: rtl/can_err_tracker_chk.sv
module can_err_tracker_chk (
  input logic        clk,
  input logic        rst,
  input logic        ev_tx_ok_i,
  input logic        ev_rx_ok_i,
  input logic        ev_err_i,
  input logic        recover_i,
  input logic        host_wr_i,
  input logic [7:0]  host_wdata_i,
  input logic [7:0]  status_o,
  input logic [15:0] errcnt_o,
  input logic [15:0] int_reg_o,
  input logic        irq_o
);
  logic quiet;
  assign quiet = !ev_tx_ok_i && !ev_rx_ok_i && !ev_err_i;

  p_code_write_r3: assert property (@(posedge clk) disable iff (rst)
    (host_wr_i && quiet) |=> status_o[2:0] == $past(host_wdata_i[2:0]));

  p_code_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!host_wr_i && quiet) |=> $stable(status_o[2:0]));

  p_rxok_set_r4: assert property (@(posedge clk) disable iff (rst)
    ev_rx_ok_i |=> status_o[4]);

  p_off_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (status_o[7] && !recover_i) |=> status_o[7]);

  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (status_o[7] && !recover_i) |=> $stable(errcnt_o));

  p_recover_r10: assert property (@(posedge clk) disable iff (rst)
    recover_i |=> (errcnt_o == 16'h0000) && !status_o[7]);

  p_irq_on_change_r11: assert property (@(posedge clk) disable iff (rst)
    (status_o[7:5] != $past(status_o[7:5])) |-> irq_o);

  p_int_word_r11: assert property (@(posedge clk) disable iff (rst)
    (int_reg_o == 16'h0000) || (int_reg_o == 16'h8000 && irq_o));
endmodule

bind can_err_tracker can_err_tracker_chk u_chk (
  .clk(clk), .rst(rst), .ev_tx_ok_i(ev_tx_ok_i), .ev_rx_ok_i(ev_rx_ok_i),
  .ev_err_i(ev_err_i), .recover_i(recover_i), .host_wr_i(host_wr_i),
  .host_wdata_i(host_wdata_i), .status_o(status_o), .errcnt_o(errcnt_o),
  .int_reg_o(int_reg_o), .irq_o(irq_o)
);

// File: tb/can_err_tracker_test.sv
module can_err_tracker_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ev_tx_ok, ev_rx_ok, ev_err, ev_err_tx, recover, host_wr;
  logic [2:0]  ev_code;
  logic [7:0]  host_wdata;
  logic [7:0]  status;
  logic [15:0] errcnt, int_reg;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  can_err_tracker uut (
    .clk(clk), .rst(rst), .ev_tx_ok_i(ev_tx_ok), .ev_rx_ok_i(ev_rx_ok),
    .ev_err_i(ev_err), .ev_err_code_i(ev_code), .ev_err_tx_i(ev_err_tx),
    .recover_i(recover), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .status_o(status), .errcnt_o(errcnt), .int_reg_o(int_reg), .irq_o(irq)
  );

  typedef struct packed {
    logic        txok;
    logic        rxok;
    logic        err;
    logic [2:0]  code;
    logic        istx;
    logic        wr;
    logic [7:0]  wd;
    logic [7:0]  st;
    logic [15:0] ec;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h08, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h18, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 8'h07, 8'h07, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h07, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 8'h00, 8'h01, 16'h0100},
    '{1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0, 8'h00, 8'h03, 16'h0108},
    '{1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h10, 16'h0008},
    '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h18, 16'h0007},
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0007}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_tx_ok = 0; ev_rx_ok = 0; ev_err = 0; ev_code = 0; ev_err_tx = 0;
    recover = 0; host_wr = 0; host_wdata = 0;
  endtask

  task automatic step(input logic txok, input logic rxok, input logic err,
                      input logic [2:0] code, input logic istx,
                      input logic wr, input logic [7:0] wd, input logic rc);
    ev_tx_ok = txok; ev_rx_ok = rxok; ev_err = err; ev_code = code;
    ev_err_tx = istx; host_wr = wr; host_wdata = wd; recover = rc;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic errs(input int n, input logic istx, input logic [2:0] code);
    for (int i = 0; i < n; i++) step(0, 0, 1, code, istx, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {8'h0, status}, 16'h0000);
    chk("R1 errcnt", errcnt, 16'h0000);
    chk("R1 intreg", int_reg, 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0000);

    // R2 R3 R4 R5 R6 table walk
    for (int v = 0; v < NV; v++) begin
      step(VEC[v].txok, VEC[v].rxok, VEC[v].err, VEC[v].code, VEC[v].istx,
           VEC[v].wr, VEC[v].wd, 1'b0);
      chk($sformatf("R2_R4 vec%0d status", v), {8'h0, status}, {8'h0, VEC[v].st});
      chk($sformatf("R5_R6 vec%0d errcnt", v), errcnt, VEC[v].ec);
      chk($sformatf("R11 vec%0d irq", v), {15'h0, irq}, 16'h0000);
    end

    // transmit count now 7: walk warning, passive, bus-off
    errs(11, 1, 3'd3);
    chk("R7 tec95 errcnt", errcnt, 16'h005F);
    chk("R7 tec95 status", {8'h0, status}, 16'h0003);
    errs(1, 1, 3'd3);
    chk("R7 tec103 status", {8'h0, status}, 16'h0043);
    chk("R11 warn irq", {15'h0, irq}, 16'h0001);
    chk("R11 warn intreg", int_reg, 16'h8000);
    step(0, 0, 0, 0, 0, 1, 8'h07, 0);
    chk("R11 ack irq", {15'h0, irq}, 16'h0000);
    chk("R3 sentinel", {8'h0, status}, 16'h0047);
    step(0, 0, 0, 0, 0, 0, 8'h00, 0);
    chk("R3 sentinel holds", {8'h0, status}, 16'h0047);
    errs(3, 1, 3'd3);
    chk("R8 tec127 status", {8'h0, status}, 16'h0043);
    chk("R8 tec127 irq", {15'h0, irq}, 16'h0000);
    errs(1, 1, 3'd3);
    chk("R8 tec135 status", {8'h0, status}, 16'h0063);
    chk("R11 pass irq", {15'h0, irq}, 16'h0001);
    step(0, 0, 0, 0, 0, 1, 8'h07, 0);
    errs(15, 1, 3'd3);
    chk("R9 tec255 errcnt", errcnt, 16'h00FF);
    chk("R9 tec255 status", {8'h0, status}, 16'h0063);
    errs(1, 1, 3'd3);
    chk("R9 busoff status", {8'h0, status}, 16'h00E3);
    chk("R6 busoff errcnt", errcnt, 16'h00FF);
    chk("R11 busoff irq", {15'h0, irq}, 16'h0001);
    step(0, 0, 0, 0, 0, 1, 8'h07, 0);
    step(0, 0, 1, 3'd2, 0, 0, 8'h00, 0);
    chk("R9 frozen rx err", errcnt, 16'h00FF);
    step(1, 0, 0, 0, 0, 0, 8'h00, 0);
    chk("R9 frozen tx ok", errcnt, 16'h00FF);
    chk("R9 sticky", {15'h0, status[7]}, 16'h0001);
    step(0, 0, 0, 0, 0, 0, 8'h00, 1);
    chk("R10 recover errcnt", errcnt, 16'h0000);
    chk("R10 recover flags", {13'h0, status[7:5]}, 16'h0000);
    chk("R11 recover irq", {15'h0, irq}, 16'h0001);
    step(0, 0, 0, 0, 0, 1, 8'h00, 0);
    chk("R4 write clears", {8'h0, status}, 16'h0000);

    // receive side
    errs(95, 0, 3'd1);
    chk("R7 rec95 errcnt", errcnt, 16'h5F00);
    chk("R7 rec95 warn", {15'h0, status[6]}, 16'h0000);
    errs(1, 0, 3'd1);
    chk("R7 rec96 errcnt", errcnt, 16'h6000);
    chk("R7 rec96 status", {8'h0, status}, 16'h0041);
    step(0, 0, 0, 0, 0, 1, 8'h07, 0);
    errs(31, 0, 3'd1);
    chk("R6 rec127 errcnt", errcnt, 16'h7F00);
    chk("R8 rec127 status", {8'h0, status}, 16'h0041);
    errs(1, 0, 3'd1);
    chk("R6 rec128 errcnt", errcnt, 16'h8000);
    chk("R8 rec128 status", {8'h0, status}, 16'h0061);
    chk("R11 rx pass irq", {15'h0, irq}, 16'h0001);
    step(0, 0, 0, 0, 0, 1, 8'h07, 0);
    errs(1, 0, 3'd1);
    chk("R5 rec saturates", errcnt, 16'h8000);
    step(0, 1, 0, 0, 0, 0, 8'h00, 0);
    chk("R5 rec decrement", errcnt, 16'h7F00);
    chk("R8 leave passive", {8'h0, status}, 16'h0050);
    chk("R11 leave irq", {15'h0, irq}, 16'h0001);
    step(0, 0, 0, 0, 0, 0, 8'h00, 1);
    step(0, 0, 0, 0, 0, 1, 8'h00, 0);

    // write and event in one cycle
    step(0, 0, 1, 3'd5, 0, 1, 8'h07, 0);
    chk("R3 event beats write", {8'h0, status}, 16'h0005);
    chk("R5 rx error count", errcnt, 16'h0100);
    step(1, 0, 0, 0, 0, 1, 8'h07, 0);
    chk("R4 txok beats write", {8'h0, status}, 16'h0008);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule